// File: doc/BRIEF.md
# Round-Robin Multi-Master AXI-Lite Arbiter

This block lets a parameterised number of AXI-Lite masters share one AXI-Lite slave. Each master is granted the slave for one complete transaction at a time. The granted master's address, data and handshake signals go to the slave. The slave's response comes back only to that master, and every other master sees its ready and response-valid signals held low. Writes and reads have separate grant machines, so a write from one master and a read from another can be in flight together.

Selection rotates in ascending index order and wraps from the last master to master 0. A master that raises its next request in the very cycle after its response handshake keeps the slave, so a burst of back-to-back transactions from one master is not broken up. If the owner leaves that cycle idle, the grant passes to the next requesting master.

Each direction runs the same four-state machine:

- `ARB_IDLE`: no owner.
- `ARB_REQ`: the address phase, plus the data phase for writes.
- `ARB_RESP`: waiting for the response handshake.
- `ARB_LINGER`: one cycle after completion that decides whether to keep or pass the grant.

The transitions are:

- **grant**: `ARB_IDLE`→`ARB_REQ` when any master requests.
- **issue**: `ARB_REQ`→`ARB_RESP` when the request phase completes.
- **retire**: `ARB_RESP`→`ARB_LINGER` on the response handshake.
- **keep**: `ARB_LINGER`→`ARB_REQ` with the same owner when that owner requests again.
- **rotate**: `ARB_LINGER`→`ARB_REQ` with a new owner when the owner is silent but another master requests.
- **release**: `ARB_LINGER`→`ARB_IDLE` when no master requests.

Top module: `axil_rr_arbiter`

## Requirements
- R1: After reset no master sees ready, `m_bvalid` or `m_rvalid` high and the slave sees no valid. The rotation pointer starts at master 0, so simultaneous first requests go to master 0.
- R2: A new owner is the first requesting master at or after the pointer in ascending index order, wrapping from N_MST-1 to 0. The pointer then moves to one past the new owner.
- R3: If the owner requests again in the cycle right after its response handshake, it keeps the grant. With three masters each doing four back-to-back writes, the slave sees 0,1,2,3,100,101,102,103,200,201,202,203 (address = 100×master + step).
- R4: If the owner leaves that cycle idle and another master requests, the grant rotates. With one idle cycle between transactions, the slave sees 0,100,200,1,101,201,2,102,202,3,103,203.
- R5: The read path applies the same keep and rotate policy with its own independent grant state, giving the same per-master ordering of reads at the slave.
- R6: The 2-bit write response code and the read data and 2-bit read response code reach the issuing master unchanged.
- R7: A master that is not granted sees `m_awready`, `m_wready`, `m_arready`, `m_bvalid` and `m_rvalid` low. At most one bit of each of these vectors is high in any cycle.
- R8: The owner of a direction does not change between its grant and its response handshake.
- R9: While no master requests, the slave sees no `s_awvalid`, `s_wvalid` or `s_arvalid`, and the pointer keeps its value.
- R10: The write request phase ends only after both the AW and the W handshakes. These may occur in different cycles, and the data written is the owner's data for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_awaddr | input | N_MST*ADDR_W | Write addresses, master i at slice i |
| m_awvalid | input | N_MST | Write address valid per master |
| m_awready | output | N_MST | Write address ready per master |
| m_wdata | input | N_MST*DATA_W | Write data per master |
| m_wstrb | input | N_MST*DATA_W/8 | Write byte strobes per master |
| m_wvalid | input | N_MST | Write data valid per master |
| m_wready | output | N_MST | Write data ready per master |
| m_bresp | output | N_MST*2 | Write response code per master |
| m_bvalid | output | N_MST | Write response valid per master |
| m_bready | input | N_MST | Write response ready per master |
| m_araddr | input | N_MST*ADDR_W | Read addresses per master |
| m_arvalid | input | N_MST | Read address valid per master |
| m_arready | output | N_MST | Read address ready per master |
| m_rdata | output | N_MST*DATA_W | Read data per master |
| m_rresp | output | N_MST*2 | Read response code per master |
| m_rvalid | output | N_MST | Read data valid per master |
| m_rready | input | N_MST | Read data ready per master |
| s_awaddr | output | ADDR_W | Write address to slave |
| s_awvalid | output | 1 | Write address valid to slave |
| s_awready | input | 1 | Write address ready from slave |
| s_wdata | output | DATA_W | Write data to slave |
| s_wstrb | output | DATA_W/8 | Write strobes to slave |
| s_wvalid | output | 1 | Write data valid to slave |
| s_wready | input | 1 | Write data ready from slave |
| s_bresp | input | 2 | Write response code from slave |
| s_bvalid | input | 1 | Write response valid from slave |
| s_bready | output | 1 | Write response ready to slave |
| s_araddr | output | ADDR_W | Read address to slave |
| s_arvalid | output | 1 | Read address valid to slave |
| s_arready | input | 1 | Read address ready from slave |
| s_rdata | input | DATA_W | Read data from slave |
| s_rresp | input | 2 | Read response code from slave |
| s_rvalid | input | 1 | Read data valid from slave |
| s_rready | output | 1 | Read data ready to slave |

## Verification
The checker watches the following on every cycle:

- exclusivity of the per-master ready and response-valid vectors;
- routing of each response to the current owner with its code unchanged;
- owner stability from grant to response;
- silence toward the slave outside the request phase;
- pointer stability while idle;
- the keep and rotate decisions in the linger cycle.

The overall order of transactions at the slave can only be shown by scenarios that run several masters concurrently. The same holds for pointer wrap-around after an idle gap and for write data that reaches the slave paired with the right address when AW and W complete in different cycles.

// File: rtl/axil_arb_pkg.sv
package axil_arb_pkg;

    // Grant machine states, shared by the write and read paths
    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_REQ    = 2'd1,
        ARB_RESP   = 2'd2,
        ARB_LINGER = 2'd3
    } arb_state_t;

endpackage

// File: rtl/axil_rr_pick.sv
module axil_rr_pick #(
    parameter int N_MST = 3,
    parameter int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic [N_MST-1:0] req,
    input  logic [IDX_W-1:0] base,
    output logic             hit,
    output logic [IDX_W-1:0] sel
);

    // Scan from the farthest offset down, so the nearest requester wins
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int k = N_MST - 1; k >= 0; k--) begin
            int unsigned pos;
            pos = int'(base) + k;
            if (pos >= N_MST) begin
                pos = pos - N_MST;
            end
            if (req[pos]) begin
                hit = 1'b1;
                sel = IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/axil_grant_fsm.sv
module axil_grant_fsm
    import axil_arb_pkg::*;
#(
    parameter int N_MST = 3,
    parameter int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    input  logic             req_done,
    input  logic             rsp_done,
    output arb_state_t       state,
    output logic [IDX_W-1:0] owner,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_MST - 1);

    arb_state_t       state_n;
    logic [IDX_W-1:0] owner_n;
    logic [IDX_W-1:0] ptr_n;
    logic             pick_hit;
    logic [IDX_W-1:0] pick_sel;

    axil_rr_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) u_pick (
        .req  (req),
        .base (ptr),
        .hit  (pick_hit),
        .sel  (pick_sel)
    );

    function automatic logic [IDX_W-1:0] after(input logic [IDX_W-1:0] idx);
        return (idx == LAST_IDX) ? '0 : idx + 1'b1;
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
            owner <= '0;
            ptr   <= '0;
        end else begin
            state <= state_n;
            owner <= owner_n;
            ptr   <= ptr_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state;
        owner_n = owner;
        ptr_n   = ptr;
        unique case (state)
            ARB_IDLE: begin
                if (pick_hit) begin            // grant
                    owner_n = pick_sel;
                    ptr_n   = after(pick_sel);
                    state_n = ARB_REQ;
                end
            end
            ARB_REQ: begin
                if (req_done) state_n = ARB_RESP;   // issue
            end
            ARB_RESP: begin
                if (rsp_done) state_n = ARB_LINGER; // retire
            end
            ARB_LINGER: begin
                if (req[owner]) begin               // keep
                    state_n = ARB_REQ;
                end else if (pick_hit) begin        // rotate
                    owner_n = pick_sel;
                    ptr_n   = after(pick_sel);
                    state_n = ARB_REQ;
                end else begin                      // release
                    state_n = ARB_IDLE;
                end
            end
            default: state_n = ARB_IDLE;
        endcase
    end

endmodule

// File: rtl/axil_wr_phase.sv
module axil_wr_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic aw_hs,
    input  logic w_hs,
    output logic aw_open,
    output logic w_open,
    output logic done
);

    logic aw_seen;
    logic w_seen;

    assign aw_open = !aw_seen;
    assign w_open  = !w_seen;
    assign done    = active && (aw_seen || aw_hs) && (w_seen || w_hs);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_seen <= 1'b0;
            w_seen  <= 1'b0;
        end else if (done) begin
            aw_seen <= 1'b0;
            w_seen  <= 1'b0;
        end else if (active) begin
            if (aw_hs) aw_seen <= 1'b1;
            if (w_hs)  w_seen  <= 1'b1;
        end
    end

endmodule

// File: rtl/axil_rr_arbiter.sv
module axil_rr_arbiter
    import axil_arb_pkg::*;
#(
    parameter int N_MST  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_MST*ADDR_W-1:0]    m_awaddr,
    input  logic [N_MST-1:0]           m_awvalid,
    output logic [N_MST-1:0]           m_awready,
    input  logic [N_MST*DATA_W-1:0]    m_wdata,
    input  logic [N_MST*DATA_W/8-1:0]  m_wstrb,
    input  logic [N_MST-1:0]           m_wvalid,
    output logic [N_MST-1:0]           m_wready,
    output logic [N_MST*2-1:0]         m_bresp,
    output logic [N_MST-1:0]           m_bvalid,
    input  logic [N_MST-1:0]           m_bready,
    input  logic [N_MST*ADDR_W-1:0]    m_araddr,
    input  logic [N_MST-1:0]           m_arvalid,
    output logic [N_MST-1:0]           m_arready,
    output logic [N_MST*DATA_W-1:0]    m_rdata,
    output logic [N_MST*2-1:0]         m_rresp,
    output logic [N_MST-1:0]           m_rvalid,
    input  logic [N_MST-1:0]           m_rready,
    output logic [ADDR_W-1:0]          s_awaddr,
    output logic                       s_awvalid,
    input  logic                       s_awready,
    output logic [DATA_W-1:0]          s_wdata,
    output logic [DATA_W/8-1:0]        s_wstrb,
    output logic                       s_wvalid,
    input  logic                       s_wready,
    input  logic [1:0]                 s_bresp,
    input  logic                       s_bvalid,
    output logic                       s_bready,
    output logic [ADDR_W-1:0]          s_araddr,
    output logic                       s_arvalid,
    input  logic                       s_arready,
    input  logic [DATA_W-1:0]          s_rdata,
    input  logic [1:0]                 s_rresp,
    input  logic                       s_rvalid,
    output logic                       s_rready
);

    localparam int IDX_W  = (N_MST > 1) ? $clog2(N_MST) : 1;
    localparam int STRB_W = DATA_W / 8;

    arb_state_t       wr_state;
    logic [IDX_W-1:0] wr_owner;
    logic [IDX_W-1:0] wr_ptr;
    arb_state_t       rd_state;
    logic [IDX_W-1:0] rd_owner;
    logic [IDX_W-1:0] rd_ptr;

    logic wr_in_req, wr_in_rsp, rd_in_req, rd_in_rsp;
    logic aw_open, w_open, wr_req_done, wr_rsp_done;
    logic rd_req_done, rd_rsp_done;
    logic aw_hs, w_hs;

    assign wr_in_req = (wr_state == ARB_REQ);
    assign wr_in_rsp = (wr_state == ARB_RESP);
    assign rd_in_req = (rd_state == ARB_REQ);
    assign rd_in_rsp = (rd_state == ARB_RESP);

    // ---------------- write path ----------------
    axil_grant_fsm #(.N_MST(N_MST), .IDX_W(IDX_W)) u_wr_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (m_awvalid),
        .req_done (wr_req_done),
        .rsp_done (wr_rsp_done),
        .state    (wr_state),
        .owner    (wr_owner),
        .ptr      (wr_ptr)
    );

    axil_wr_phase u_wr_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (wr_in_req),
        .aw_hs   (aw_hs),
        .w_hs    (w_hs),
        .aw_open (aw_open),
        .w_open  (w_open),
        .done    (wr_req_done)
    );

    assign s_awaddr  = m_awaddr[wr_owner*ADDR_W +: ADDR_W];
    assign s_wdata   = m_wdata[wr_owner*DATA_W +: DATA_W];
    assign s_wstrb   = m_wstrb[wr_owner*STRB_W +: STRB_W];
    assign s_awvalid = wr_in_req && aw_open && m_awvalid[wr_owner];
    assign s_wvalid  = wr_in_req && w_open && m_wvalid[wr_owner];
    assign s_bready  = wr_in_rsp && m_bready[wr_owner];
    assign aw_hs       = s_awvalid && s_awready;
    assign w_hs        = s_wvalid && s_wready;
    assign wr_rsp_done = s_bvalid && s_bready;
    assign m_bresp     = {N_MST{s_bresp}};

    always_comb begin
        m_awready = '0;
        m_wready  = '0;
        m_bvalid  = '0;
        m_awready[wr_owner] = wr_in_req && aw_open && s_awready;
        m_wready[wr_owner]  = wr_in_req && w_open && s_wready;
        m_bvalid[wr_owner]  = wr_in_rsp && s_bvalid;
    end

    // ---------------- read path ----------------
    axil_grant_fsm #(.N_MST(N_MST), .IDX_W(IDX_W)) u_rd_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (m_arvalid),
        .req_done (rd_req_done),
        .rsp_done (rd_rsp_done),
        .state    (rd_state),
        .owner    (rd_owner),
        .ptr      (rd_ptr)
    );

    assign s_araddr    = m_araddr[rd_owner*ADDR_W +: ADDR_W];
    assign s_arvalid   = rd_in_req && m_arvalid[rd_owner];
    assign s_rready    = rd_in_rsp && m_rready[rd_owner];
    assign rd_req_done = s_arvalid && s_arready;
    assign rd_rsp_done = s_rvalid && s_rready;
    assign m_rdata     = {N_MST{s_rdata}};
    assign m_rresp     = {N_MST{s_rresp}};

    always_comb begin
        m_arready = '0;
        m_rvalid  = '0;
        m_arready[rd_owner] = rd_in_req && s_arready;
        m_rvalid[rd_owner]  = rd_in_rsp && s_rvalid;
    end

endmodule

// File: rtl/axil_rr_arbiter_chk.sv
module axil_rr_arbiter_chk
    import axil_arb_pkg::*;
#(
    parameter int N_MST = 3,
    parameter int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MST-1:0] m_awvalid,
    input logic [N_MST-1:0] m_arvalid,
    input logic [N_MST-1:0] m_awready,
    input logic [N_MST-1:0] m_wready,
    input logic [N_MST-1:0] m_arready,
    input logic [N_MST-1:0] m_bvalid,
    input logic [N_MST-1:0] m_rvalid,
    input logic [N_MST*2-1:0] m_bresp,
    input logic [N_MST*2-1:0] m_rresp,
    input logic [1:0]       s_bresp,
    input logic [1:0]       s_rresp,
    input logic             s_bvalid,
    input logic             s_rvalid,
    input logic             s_awvalid,
    input logic             s_wvalid,
    input logic             s_arvalid,
    input arb_state_t       wr_state,
    input logic [IDX_W-1:0] wr_owner,
    input logic [IDX_W-1:0] wr_ptr,
    input arb_state_t       rd_state,
    input logic [IDX_W-1:0] rd_owner,
    input logic [IDX_W-1:0] rd_ptr
);

    // R7: at most one master sees each ready or response valid
    p_one_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_awready) && $onehot0(m_wready) && $onehot0(m_arready));
    p_one_rspvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_bvalid) && $onehot0(m_rvalid));

    // R6: slave responses reach the owner with the code unchanged
    p_bresp_routed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && wr_state == ARB_RESP) |->
            (m_bvalid[wr_owner] && m_bresp[wr_owner*2 +: 2] == s_bresp));
    p_rresp_routed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && rd_state == ARB_RESP) |->
            (m_rvalid[rd_owner] && m_rresp[rd_owner*2 +: 2] == s_rresp));

    // R8: no owner change mid-transaction
    p_wr_owner_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state == ARB_REQ || wr_state == ARB_RESP) |=> $stable(wr_owner));
    p_rd_owner_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == ARB_REQ || rd_state == ARB_RESP) |=> $stable(rd_owner));

    // R9: silence toward the slave outside the request phase, pointer frozen while idle
    p_wr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state != ARB_REQ) |-> (!s_awvalid && !s_wvalid));
    p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state != ARB_REQ) |-> !s_arvalid);
    p_wr_ptr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state == ARB_IDLE && m_awvalid == '0) |=> $stable(wr_ptr));
    p_rd_ptr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == ARB_IDLE && m_arvalid == '0) |=> $stable(rd_ptr));

    // R3: owner asking again in the linger cycle keeps the grant
    p_wr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state == ARB_LINGER && m_awvalid[wr_owner]) |=>
            (wr_state == ARB_REQ && $stable(wr_owner)));

    // R4: silent owner with other requesters hands over
    p_wr_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state == ARB_LINGER && !m_awvalid[wr_owner] && m_awvalid != '0) |=>
            (wr_state == ARB_REQ && !$stable(wr_owner)));

    // R5: the read path keeps the grant the same way
    p_rd_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == ARB_LINGER && m_arvalid[rd_owner]) |=>
            (rd_state == ARB_REQ && $stable(rd_owner)));

endmodule

bind axil_rr_arbiter axil_rr_arbiter_chk #(.N_MST(N_MST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_awvalid (m_awvalid),
    .m_arvalid (m_arvalid),
    .m_awready (m_awready),
    .m_wready  (m_wready),
    .m_arready (m_arready),
    .m_bvalid  (m_bvalid),
    .m_rvalid  (m_rvalid),
    .m_bresp   (m_bresp),
    .m_rresp   (m_rresp),
    .s_bresp   (s_bresp),
    .s_rresp   (s_rresp),
    .s_bvalid  (s_bvalid),
    .s_rvalid  (s_rvalid),
    .s_awvalid (s_awvalid),
    .s_wvalid  (s_wvalid),
    .s_arvalid (s_arvalid),
    .wr_state  (wr_state),
    .wr_owner  (wr_owner),
    .wr_ptr    (wr_ptr),
    .rd_state  (rd_state),
    .rd_owner  (rd_owner),
    .rd_ptr    (rd_ptr)
);

// File: tb/tb_axil_rr_arbiter.sv
module tb_axil_rr_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 3;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;
    localparam int STEPS = 4;
    localparam int LOG_MAX = 64;

    // Expected slave-side address order; scenario index = idle cycles between transactions
    localparam int EXP_ORD [2][12] = '{
        '{0, 1, 2, 3, 100, 101, 102, 103, 200, 201, 202, 203},
        '{0, 100, 200, 1, 101, 201, 2, 102, 202, 3, 103, 203}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [N*AW-1:0] m_awaddr, m_araddr;
    logic [N*DW-1:0] m_wdata, m_rdata;
    logic [N*SW-1:0] m_wstrb;
    logic [N-1:0]    m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
    logic [N-1:0]    m_arvalid, m_arready, m_rvalid, m_rready;
    logic [N*2-1:0]  m_bresp, m_rresp;
    logic [AW-1:0]   s_awaddr, s_araddr;
    logic [DW-1:0]   s_wdata, s_rdata;
    logic [SW-1:0]   s_wstrb;
    logic            s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
    logic            s_arvalid, s_arready, s_rvalid, s_rready;
    logic [1:0]      s_bresp, s_rresp;

    // per-master drive state
    logic [AW-1:0] awa [N];
    logic [AW-1:0] ara [N];
    logic [DW-1:0] wd  [N];
    logic [N-1:0]  awv = '0, wv = '0, bre = '0, arv = '0, rre = '0;

    for (genvar g = 0; g < N; g++) begin : g_drv
        assign m_awaddr[g*AW +: AW] = awa[g];
        assign m_araddr[g*AW +: AW] = ara[g];
        assign m_wdata[g*DW +: DW]  = wd[g];
    end
    assign m_wstrb   = '1;
    assign m_awvalid = awv;
    assign m_wvalid  = wv;
    assign m_bready  = bre;
    assign m_arvalid = arv;
    assign m_rready  = rre;

    axil_rr_arbiter #(.N_MST(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
    );

    function automatic logic [DW-1:0] wpat(input int a);
        return DW'(a) ^ 32'h0F0F_0000;
    endfunction
    function automatic logic [DW-1:0] rpat(input int a);
        return DW'(a) ^ 32'h5A5A_0000;
    endfunction

    // ---------------- slave model: W accepted one cycle after AW ----------------
    logic          aw_got = 1'b0, b_pend = 1'b0, r_pend = 1'b0;
    logic [AW-1:0] aw_lat;
    logic [1:0]    bresp_q, rresp_q;
    logic [DW-1:0] rdata_q;
    int            wlog_a [LOG_MAX];
    int            wlog_d [LOG_MAX];
    int            rlog_a [LOG_MAX];
    int            wn = 0, rn = 0;

    assign s_awready = !aw_got && !b_pend;
    assign s_wready  = aw_got;
    assign s_bvalid  = b_pend;
    assign s_bresp   = bresp_q;
    assign s_arready = !r_pend;
    assign s_rvalid  = r_pend;
    assign s_rdata   = rdata_q;
    assign s_rresp   = rresp_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            aw_got <= 1'b0; b_pend <= 1'b0; r_pend <= 1'b0;
            aw_lat <= '0; bresp_q <= '0; rresp_q <= '0; rdata_q <= '0;
        end else begin
            if (s_awvalid && s_awready) begin
                aw_got <= 1'b1;
                aw_lat <= s_awaddr;
            end
            if (s_wvalid && s_wready) begin
                aw_got  <= 1'b0;
                b_pend  <= 1'b1;
                bresp_q <= aw_lat[1:0];
                if (wn < LOG_MAX) begin
                    wlog_a[wn] <= int'(aw_lat);
                    wlog_d[wn] <= int'(s_wdata);
                end
                wn <= wn + 1;
            end
            if (s_bvalid && s_bready) b_pend <= 1'b0;
            if (s_arvalid && s_arready) begin
                r_pend  <= 1'b1;
                rdata_q <= rpat(int'(s_araddr));
                rresp_q <= s_araddr[1:0];
                if (rn < LOG_MAX) rlog_a[rn] <= int'(s_araddr);
                rn <= rn + 1;
            end
            if (s_rvalid && s_rready) r_pend <= 1'b0;
        end
    end

    // ---------------- bookkeeping ----------------
    int checks = 0, errors = 0;
    int route_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R7 monitor: exclusivity and no response to a master that is not waiting
    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(m_awready) > 1 || $countones(m_wready) > 1 ||
                $countones(m_arready) > 1 || $countones(m_bvalid) > 1 ||
                $countones(m_rvalid) > 1)
                route_bad++;
            if ((m_bvalid & ~bre) != '0 || (m_rvalid & ~rre) != '0)
                route_bad++;
        end
    end

    // ---------------- master tasks (called at a falling edge, return at one) ----------------
    task automatic mwrite(input int i, input int a);
        bit aw_ok, w_ok, got, ha, hw;
        logic [1:0] resp;
        awa[i] = AW'(a); wd[i] = wpat(a);
        awv[i] = 1'b1; wv[i] = 1'b1;
        aw_ok = 1'b0; w_ok = 1'b0;
        while (!(aw_ok && w_ok)) begin
            #1;
            ha = awv[i] && m_awready[i];
            hw = wv[i] && m_wready[i];
            @(negedge clk);
            if (ha) begin awv[i] = 1'b0; aw_ok = 1'b1; end
            if (hw) begin wv[i] = 1'b0; w_ok = 1'b1; end
        end
        bre[i] = 1'b1;
        got = 1'b0;
        resp = '0;
        while (!got) begin
            #1;
            if (m_bvalid[i]) begin got = 1'b1; resp = m_bresp[i*2 +: 2]; end
            @(negedge clk);
        end
        bre[i] = 1'b0;
        chk(resp == 2'(a), "R6", "write response code", resp, 2'(a));
    endtask

    task automatic mread(input int i, input int a);
        bit ok, got;
        logic [1:0] resp;
        logic [DW-1:0] dat;
        ara[i] = AW'(a);
        arv[i] = 1'b1;
        ok = 1'b0;
        while (!ok) begin
            #1;
            ok = m_arready[i];
            @(negedge clk);
        end
        arv[i] = 1'b0;
        rre[i] = 1'b1;
        got = 1'b0;
        resp = '0; dat = '0;
        while (!got) begin
            #1;
            if (m_rvalid[i]) begin
                got = 1'b1; resp = m_rresp[i*2 +: 2]; dat = m_rdata[i*DW +: DW];
            end
            @(negedge clk);
        end
        rre[i] = 1'b0;
        chk(resp == 2'(a), "R6", "read response code", resp, 2'(a));
        chk(dat == rpat(a), "R6", "read data", dat, rpat(a));
    endtask

    task automatic mseq(input int i, input int gap, input bit rd);
        for (int k = 0; k < STEPS; k++) begin
            if (rd) mread(i, 100*i + k);
            else    mwrite(i, 100*i + k);
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic run_all(input int gap, input bit rd);
        fork
            mseq(0, gap, rd);
            mseq(1, gap, rd);
            mseq(2, gap, rd);
        join
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        int w0, r0;
        for (int i = 0; i < N; i++) begin awa[i] = '0; ara[i] = '0; wd[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(m_awready == '0 && m_wready == '0 && m_arready == '0, "R1", "readies in reset",
            {m_awready, m_wready, m_arready}, 0);
        chk(m_bvalid == '0 && m_rvalid == '0, "R1", "response valids in reset",
            {m_bvalid, m_rvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!s_awvalid && !s_wvalid && !s_arvalid && m_awready == '0, "R1",
            "quiet after reset", {s_awvalid, s_wvalid, s_arvalid}, 0);

        // Table walk: scenario s uses s idle cycles between transactions
        // (R1 first grant to master 0, R3 keep, R4 rotate, R5 reads, R10 write data pairing)
        for (int s = 0; s < 2; s++) begin
            w0 = wn;
            run_all(s, 1'b0);
            repeat (4) @(negedge clk);
            chk(wn - w0 == 12, s == 0 ? "R3" : "R4", "write count", wn - w0, 12);
            for (int k = 0; k < 12; k++) begin
                chk(wlog_a[w0+k] == EXP_ORD[s][k], s == 0 ? "R3" : "R4",
                    $sformatf("write order slot %0d", k), wlog_a[w0+k], EXP_ORD[s][k]);
                chk(wlog_d[w0+k] == int'(wpat(EXP_ORD[s][k])), "R10",
                    $sformatf("write data slot %0d", k), wlog_d[w0+k], wpat(EXP_ORD[s][k]));
            end
            r0 = rn;
            run_all(s, 1'b1);
            repeat (4) @(negedge clk);
            chk(rn - r0 == 12, "R5", "read count", rn - r0, 12);
            for (int k = 0; k < 12; k++)
                chk(rlog_a[r0+k] == EXP_ORD[s][k], "R5",
                    $sformatf("read order slot %0d", k), rlog_a[r0+k], EXP_ORD[s][k]);
        end

        // R9 + R2: single write from master 0 moves pointer to 1, idle gap, then 0 and 2 compete
        mwrite(0, 400);
        begin
            bit quiet = 1'b1;
            for (int c = 0; c < 10; c++) begin
                #1;
                if (s_awvalid || s_wvalid || s_arvalid) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R9", "slave valids while idle", !quiet, 0);
        end
        w0 = wn;
        fork
            mwrite(0, 500);
            mwrite(2, 702);
        join
        repeat (4) @(negedge clk);
        chk(wlog_a[w0] == 702, "R2", "pointer kept through idle, master 2 first", wlog_a[w0], 702);
        chk(wlog_a[w0+1] == 500, "R2", "wrap to master 0 next", wlog_a[w0+1], 500);

        // R8 + R7: read and write simultaneously from different masters, then routing summary
        fork
            mwrite(1, 801);
            mread(2, 902);
        join
        repeat (4) @(negedge clk);
        chk(wlog_a[wn-1] == 801, "R8", "concurrent write kept its owner", wlog_a[wn-1], 801);
        chk(rlog_a[rn-1] == 902, "R8", "concurrent read kept its owner", rlog_a[rn-1], 902);
        chk(route_bad == 0, "R7", "non-granted masters saw ready or response", route_bad, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule